// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This controller decides when each of four supply rails may begin to ramp. The analog soft-start ramps, error amplifiers, PWM modulators and level comparators sit outside it. It sees only their digital results: a power-on-reset-complete flag, one power-good flag per rail, two ramp-finished flags, a strobe that marks each PWM pulse on rail 1, and a flag that says rail 2 is still above its minimum level. From these it drives a release for the first soft-start group (rails 2 and 4), a release for the second group (rails 1 and 3, which share one ramp), a termination-good flag and a global power-good flag.

The linear drive for rail 4 is enabled as soon as reset ends. It does not wait for power-on reset, so that rail can track its auxiliary input early. The two ramp groups are chained: the second group is only released once rail 2 reports power-good. A separate fault block can send the sequencer back to its waiting state through a synchronous restart input.

Top module: `pwr_seq`

## Requirements
- R1: `rail4DriveEn` is high from the first clock edge after `rstN` is released, whatever `porDone` is, and `restart` does not lower it.
- R2: In the waiting state, a high `porDone` sampled at an edge raises `ss24Release` after that edge. It stays high until `restart` or reset.
- R3: `ss13Release` rises only after an edge at which `ss24Release` is already high and `railGood[1]` (rail 2, bit 1 of `railGood`; bit 0 is rail 1, bit 3 is rail 4) is high. Rails 1 and 3 share this single release.
- R4: The first `pwmPulse1` sampled while `ss13Release` is high sets `termGood` after that edge, provided `rail2AboveMin` is high at the same edge.
- R5: If `rail2AboveMin` is low at that first pulse, `termGood` stays low. Later pulses do not set it until a `restart`. Once set, `termGood` stays high until `restart`.
- R6: `pwmPulse1` strobes sampled while `ss13Release` is low have no effect on `termGood`, and they do not count as the first pulse.
- R7: While `ss13Release` is high, `powerGood` rises after the first edge at which all four `railGood` bits, `ss24Done` and `ss13Done` are high.
- R8: While `powerGood` is high, any `railGood` bit sampled low clears it after that edge. It rises again under the rule of R7.
- R9: `restart` sampled high clears `ss24Release`, `ss13Release`, `termGood` and `powerGood` after that edge and returns the block to waiting for `porDone`. A `porDone` sampled at the same edge is ignored.
- R10: While `rstN` is low, all five outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous return to waiting state (from fault logic) |
| porDone | input | 1 | Power-on reset complete |
| railGood | input | 4 | Per-rail power-good flags, bit 0 = rail 1 … bit 3 = rail 4 |
| ss24Done | input | 1 | First-group ramp has reached its top |
| ss13Done | input | 1 | Second-group ramp has reached its top |
| pwmPulse1 | input | 1 | One-cycle strobe per PWM pulse on rail 1 |
| rail2AboveMin | input | 1 | Rail 2 is above its under-level threshold |
| rail4DriveEn | output | 1 | Linear rail-4 drive enable |
| ss24Release | output | 1 | Release of the rail 2/4 soft-start |
| ss13Release | output | 1 | Release of the rail 1/3 soft-start |
| termGood | output | 1 | Termination-good flag |
| powerGood | output | 1 | Global power-good flag |

## Verification
Every output is a register fed from the state and inputs of the previous edge. A wrong state shows at the ports one edge after the stimulus that exposes it. A state that skips a group shows as `ss13Release` without `ss24Release`, or as `powerGood` rising before all rails are good. A lost first-pulse marker shows as `termGood` rising on a later pulse after a failed first one. That is only visible if rail 2 recovers and another pulse arrives, so the stimulus deliberately toggles `rail2AboveMin` around the pulses. A restart that is not honoured shows as a release still high on the following cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    WAIT_POR  = 2'd0,
    SS24_RAMP = 2'd1,
    SS13_RAMP = 2'd2,
    ALL_GOOD  = 2'd3
  } seqState_t;

  // strobes from control to the flag datapath, valid for one cycle
  typedef struct packed {
    logic clearAll;     // restart: drop every release and flag
    logic openGroupA;   // release rails 2/4
    logic openGroupB;   // release rails 1/3
    logic raiseGood;    // all rails good, ramps finished
    logic dropGood;     // a rail left its good window
    logic pulseWindow;  // rail-1 pulses are meaningful now
  } seqStrobes_t;

endpackage

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  parameter int RAIL2_IDX = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 restart,
  input  logic                 porDone,
  input  logic [NUM_RAILS-1:0] railGood,
  input  logic                 ss24Done,
  input  logic                 ss13Done,
  output seqState_t            state,
  output seqStrobes_t          strb
);

  seqState_t nextState;
  logic      everyRailGood;
  logic      rampsFinished;

  assign everyRailGood = &railGood;
  assign rampsFinished = ss24Done & ss13Done;

  always_comb begin
    nextState = state;
    strb      = '0;
    if (restart) begin
      strb.clearAll = 1'b1;
      nextState     = WAIT_POR;
    end else begin
      unique case (state)
        WAIT_POR: begin
          if (porDone) begin
            strb.openGroupA = 1'b1;
            nextState       = SS24_RAMP;
          end
        end
        SS24_RAMP: begin
          if (railGood[RAIL2_IDX]) begin
            strb.openGroupB = 1'b1;
            nextState       = SS13_RAMP;
          end
        end
        SS13_RAMP: begin
          strb.pulseWindow = 1'b1;
          if (everyRailGood && rampsFinished) begin
            strb.raiseGood = 1'b1;
            nextState      = ALL_GOOD;
          end
        end
        ALL_GOOD: begin
          strb.pulseWindow = 1'b1;
          if (!everyRailGood) begin
            strb.dropGood = 1'b1;
            nextState     = SS13_RAMP;
          end
        end
        default: nextState = WAIT_POR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= WAIT_POR;
    else       state <= nextState;
  end

endmodule

// File: rtl/pwr_seq_flags.sv
module pwr_seq_flags
  import pwr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strb,
  input  logic        pwmPulse1,
  input  logic        rail2AboveMin,
  output logic        rail4DriveEn,
  output logic        ss24Release,
  output logic        ss13Release,
  output logic        termGood,
  output logic        powerGood
);

  logic firstPulseSeen;
  logic pulseCounts;

  assign pulseCounts = strb.pulseWindow & pwmPulse1 & ~firstPulseSeen;

  // linear rail-4 drive does not wait for power-on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rail4DriveEn <= 1'b0;
    else       rail4DriveEn <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ss24Release <= 1'b0;
      ss13Release <= 1'b0;
    end else if (strb.clearAll) begin
      ss24Release <= 1'b0;
      ss13Release <= 1'b0;
    end else begin
      if (strb.openGroupA) ss24Release <= 1'b1;
      if (strb.openGroupB) ss13Release <= 1'b1;
    end
  end

  // only the first counted pulse decides the termination flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstPulseSeen <= 1'b0;
      termGood       <= 1'b0;
    end else if (strb.clearAll) begin
      firstPulseSeen <= 1'b0;
      termGood       <= 1'b0;
    end else if (pulseCounts) begin
      firstPulseSeen <= 1'b1;
      termGood       <= rail2AboveMin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               powerGood <= 1'b0;
    else if (strb.clearAll || strb.dropGood) powerGood <= 1'b0;
    else if (strb.raiseGood)                 powerGood <= 1'b1;
  end

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  parameter int RAIL2_IDX = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 restart,
  input  logic                 porDone,
  input  logic [NUM_RAILS-1:0] railGood,
  input  logic                 ss24Done,
  input  logic                 ss13Done,
  input  logic                 pwmPulse1,
  input  logic                 rail2AboveMin,
  output logic                 rail4DriveEn,
  output logic                 ss24Release,
  output logic                 ss13Release,
  output logic                 termGood,
  output logic                 powerGood
);

  seqState_t   state;
  seqStrobes_t strb;

  pwr_seq_ctrl #(
    .NUM_RAILS(NUM_RAILS),
    .RAIL2_IDX(RAIL2_IDX)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .restart  (restart),
    .porDone  (porDone),
    .railGood (railGood),
    .ss24Done (ss24Done),
    .ss13Done (ss13Done),
    .state    (state),
    .strb     (strb)
  );

  pwr_seq_flags u_flags (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .pwmPulse1     (pwmPulse1),
    .rail2AboveMin (rail2AboveMin),
    .rail4DriveEn  (rail4DriveEn),
    .ss24Release   (ss24Release),
    .ss13Release   (ss13Release),
    .termGood      (termGood),
    .powerGood     (powerGood)
  );

endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker #(
  parameter int NUM_RAILS = 4,
  parameter int RAIL2_IDX = 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 restart,
  input logic                 porDone,
  input logic [NUM_RAILS-1:0] railGood,
  input logic                 pwmPulse1,
  input logic                 rail2AboveMin,
  input logic                 rail4DriveEn,
  input logic                 ss24Release,
  input logic                 ss13Release,
  input logic                 termGood,
  input logic                 powerGood
);

  assert_drive_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    rail4DriveEn |=> rail4DriveEn);

  assert_groupa_after_por_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ss24Release) |-> $past(porDone));

  assert_groupb_chained_R3: assert property (@(posedge clk) disable iff (!rstN)
    ss13Release |-> ss24Release);

  assert_groupb_after_rail2_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ss13Release) |-> $past(railGood[RAIL2_IDX] && ss24Release));

  assert_term_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(termGood) |-> $past(ss13Release && pwmPulse1 && rail2AboveMin));

  assert_term_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (termGood && !restart) |=> termGood);

  assert_pg_needs_rails_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerGood) |-> $past(&railGood));

  assert_pg_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
    (powerGood && !(&railGood)) |=> !powerGood);

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !ss24Release && !ss13Release && !termGood && !powerGood);

endmodule

bind pwr_seq pwr_seq_checker #(
  .NUM_RAILS(NUM_RAILS),
  .RAIL2_IDX(RAIL2_IDX)
) u_checker (
  .clk           (clk),
  .rstN          (rstN),
  .restart       (restart),
  .porDone       (porDone),
  .railGood      (railGood),
  .pwmPulse1     (pwmPulse1),
  .rail2AboveMin (rail2AboveMin),
  .rail4DriveEn  (rail4DriveEn),
  .ss24Release   (ss24Release),
  .ss13Release   (ss13Release),
  .termGood      (termGood),
  .powerGood     (powerGood)
);

// File: tb/pwr_seq_bench.sv
module pwr_seq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       restart = 1'b0;
  logic       porDone = 1'b0;
  logic [3:0] railGood = 4'b0;
  logic       ss24Done = 1'b0;
  logic       ss13Done = 1'b0;
  logic       pwmPulse1 = 1'b0;
  logic       rail2AboveMin = 1'b0;
  logic       rail4DriveEn, ss24Release, ss13Release, termGood, powerGood;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwr_seq u_pwr_seq (
    .clk(clk), .rstN(rstN), .restart(restart), .porDone(porDone),
    .railGood(railGood), .ss24Done(ss24Done), .ss13Done(ss13Done),
    .pwmPulse1(pwmPulse1), .rail2AboveMin(rail2AboveMin),
    .rail4DriveEn(rail4DriveEn), .ss24Release(ss24Release),
    .ss13Release(ss13Release), .termGood(termGood), .powerGood(powerGood)
  );

  // reference model, written from the requirements
  int   mPhase;  // 0 waiting, 1 group A open, 2 group B open, 3 all good
  logic mDrive, mA, mB, mTerm, mPg, mSeen;

  function automatic logic allReady(logic [3:0] g, logic d24, logic d13);
    return (&g) && d24 && d13;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mDrive = 0; mA = 0; mB = 0; mTerm = 0; mPg = 0; mSeen = 0;
    end else begin
      mDrive = 1'b1;                                       // R1
      if (restart) begin                                   // R9
        mPhase = 0; mA = 0; mB = 0; mTerm = 0; mPg = 0; mSeen = 0;
      end else begin
        case (mPhase)
          0: if (porDone) begin mPhase = 1; mA = 1; end      // R2
          1: if (railGood[1]) begin mPhase = 2; mB = 1; end  // R3
          default: begin
            if (pwmPulse1 && !mSeen) begin                   // R4 R5 R6
              mSeen = 1; mTerm = rail2AboveMin;
            end
            if (mPhase == 2 && allReady(railGood, ss24Done, ss13Done)) begin
              mPhase = 3; mPg = 1;                           // R7
            end else if (mPhase == 3 && !(&railGood)) begin
              mPhase = 2; mPg = 0;                           // R8
            end
          end
        endcase
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    chk("R1 rail4DriveEn", rail4DriveEn, mDrive);
    chk("R2 ss24Release", ss24Release, mA);
    chk("R3 ss13Release", ss13Release, mB);
    chk("R4/R5 termGood", termGood, mTerm);
    chk("R7/R8 powerGood", powerGood, mPg);
  endtask

  // one clock: apply inputs after a falling edge, check at the next falling edge
  task automatic step(logic rs, logic por, logic [3:0] g, logic d24, logic d13,
                      logic pw, logic r2);
    restart = rs; porDone = por; railGood = g; ss24Done = d24; ss13Done = d13;
    pwmPulse1 = pw; rail2AboveMin = r2;
    @(negedge clk);
    cycles++;
    compareAll();
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      misses++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    // R10: outputs low while reset held
    @(negedge clk); @(negedge clk);
    chk("R10 rail4DriveEn", rail4DriveEn, 1'b0);
    chk("R10 ss24Release", ss24Release, 1'b0);
    chk("R10 powerGood", powerGood, 1'b0);
    rstN = 1'b1;

    // R1: drive up without porDone; R2 still closed
    step(0, 0, 4'h0, 0, 0, 0, 1);
    chk("R1 drive without por", rail4DriveEn, 1'b1);
    chk("R2 no release without por", ss24Release, 1'b0);
    // R6: pulses before group B released are ignored
    step(0, 1, 4'h0, 0, 0, 1, 1);
    chk("R2 group A open", ss24Release, 1'b1);
    step(0, 0, 4'h0, 0, 0, 1, 1);
    chk("R6 early pulse ignored", termGood, 1'b0);
    step(0, 0, 4'b1101, 0, 0, 0, 1);
    chk("R3 held without rail2", ss13Release, 1'b0);
    step(0, 0, 4'b0010, 0, 0, 0, 1);
    chk("R3 group B open", ss13Release, 1'b1);
    // R5: first pulse with rail 2 low -> stays low, later pulse ignored
    step(0, 0, 4'b0010, 0, 0, 1, 0);
    chk("R5 first pulse rail2 low", termGood, 1'b0);
    step(0, 0, 4'b0010, 0, 0, 1, 1);
    chk("R5 later pulse ignored", termGood, 1'b0);
    // R7: not good until ramps finish
    step(0, 0, 4'hF, 1, 0, 0, 1);
    chk("R7 waits for ramp", powerGood, 1'b0);
    step(0, 0, 4'hF, 1, 1, 0, 1);
    chk("R7 power good", powerGood, 1'b1);
    step(0, 0, 4'b1011, 1, 1, 0, 1);
    chk("R8 drop on rail3", powerGood, 1'b0);
    // R9: restart with porDone ignored; drive stays
    step(1, 1, 4'hF, 1, 1, 0, 1);
    chk("R9 cleared", ss24Release, 1'b0);
    chk("R9 drive kept", rail4DriveEn, 1'b1);
    step(0, 0, 4'hF, 1, 1, 0, 1);
    chk("R9 por ignored", ss24Release, 1'b0);
    // R4: good first pulse
    step(0, 1, 4'h0, 0, 0, 0, 1);
    step(0, 0, 4'b0010, 0, 0, 0, 1);
    step(0, 0, 4'b0010, 0, 0, 1, 1);
    chk("R4 term set", termGood, 1'b1);
    step(0, 0, 4'b0000, 0, 0, 1, 0);
    chk("R5 term sticky", termGood, 1'b1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] g;
      for (int b = 0; b < 4; b++) g[b] = ($urandom % 8) != 0;
      step(($urandom % 80) == 0, ($urandom % 6) == 0, g,
           ($urandom % 4) != 0, ($urandom % 4) != 0,
           ($urandom % 5) == 0, ($urandom % 3) != 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule